// File: doc/BRIEF.md
# Vector Single-Structure Load/Store Decoder

This block is a purely combinational decoder for 32-bit instruction words in a vector load/store class. These instructions move one structure of one to four elements between memory and one lane, or all lanes, of consecutive vector registers. It sorts the word into one of three outcomes: it matches neither encoding form, it matches a form but carries an illegal field combination, or it is a legal operation. For a legal operation it derives everything a downstream load sequencer needs. That covers how many elements to move and how wide each one is, and which lane receives them. It also reports whether the element is replicated across the whole register, how wide the register view is, and whether the base register is written back. It reports whether the access is tag-checked, and whether the post-increment comes from an immediate or from a register.

The decoder sits between fetch/decode and the load/store sequencer. The sequencer acts only when `valid` is high. When `undef` or `no_match` is high, all derived outputs are don't-care. Register renumbering for the second and later elements (modulo 32) is left to the sequencer.

Top module: `vls_single_decode`

## Requirements
- R1: A word is recognised only when bit 31 is 0 and bits 29:23 equal 0011010 with bits 20:16 all zero (no-offset form), or bits 29:23 equal 0011011 (post-index form). Any other word raises `no_match` and holds `valid` and `undef` low.
- R2: `tgt_reg` is bits 4:0 and `base_reg` is bits 9:5. `ofs_reg` is bits 20:16 in both forms, so it reads 0 for the no-offset form.
- R3: `elem_count` equals the 2-bit value {bit 13, bit 21} plus one, a range of 1 to 4.
- R4: When bits 15:14 are 11 the operation replicates (`replicate`=1), the lane index is 0 and the element scale is taken from bits 11:10. The word is undefined if bit 22 is 0 or bit 12 is 1.
- R5: When bits 15:14 are 00 the element is 8 bits wide and `lane_idx` = {bit 30, bit 12, bits 11:10}.
- R6: When bits 15:14 are 01 the element is 16 bits wide. The word is undefined if bit 10 is 1; otherwise `lane_idx` = {bit 30, bit 12, bit 11}.
- R7: When bits 15:14 are 10 the word is undefined if bit 11 is 1. If bit 10 is 0 the element is 32 bits wide and `lane_idx` = {bit 30, bit 12}. If bit 10 is 1, the word is undefined when bit 12 is 1; otherwise the element is 64 bits wide and `lane_idx` = bit 30.
- R8: `reg_bits` is 64 when bit 30 is 0 and 128 when bit 30 is 1. `elem_bits` is 8 shifted left by the final scale.
- R9: `wback` is 1 only for the post-index form. `tag_chk` is 1 when `wback` is 1 or `base_reg` is not 31.
- R10: `use_imm` is 1 only for the post-index form with bits 20:16 equal to 11111. `imm_bytes` equals `elem_count` times the element size in bytes (3, 6, 12, 24 for a 3-element replicate of scale 0 to 3).
- R11: `valid` is high exactly when the word matches a form and no undefined rule applies. `undef` is high only for matching words.
- R12: `is_load` reflects bit 22 of a recognised word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word under decode |
| valid | output | 1 | Legal operation; sequencer may act |
| undef | output | 1 | Form matched but field combination is illegal |
| no_match | output | 1 | Word belongs to neither form |
| is_load | output | 1 | Load (1) or store (0) direction |
| tgt_reg | output | 5 | First vector register number |
| base_reg | output | 5 | Base address register number |
| ofs_reg | output | 5 | Post-increment register number (11111 means immediate) |
| elem_count | output | 3 | Elements per structure, 1 to 4 |
| elem_bits | output | 7 | Element width in bits, 8 to 64 |
| lane_idx | output | 4 | Lane that receives the element |
| replicate | output | 1 | Element is copied to every lane |
| reg_bits | output | 8 | Register view width, 64 or 128 |
| wback | output | 1 | Base register is updated after the access |
| tag_chk | output | 1 | Access is tag-checked |
| use_imm | output | 1 | Post-increment is the immediate |
| imm_bytes | output | 6 | Immediate post-increment in bytes |

## Verification
On every evaluation the assertions check several invariants. Exactly one of the three outcome flags is raised. A legal non-replicating lane always fits inside the register view. A legal replicate never carries the bits that make it illegal. Writeback implies tag checking, and the immediate increment appears only with writeback and an offset field of 11111. Only the bench's scenarios can show the exact values. These include the lane index arithmetic for each scale, the element counts, and the immediate sizes. They also include each individual undefined rule, and the fact that a mangled fixed field yields `no_match` rather than `undef`.

// File: rtl/vls_single_decode.sv
module vls_single_decode #(
  parameter int RW = 5
) (
  input  logic [31:0]   insn,
  output logic          valid,
  output logic          undef,
  output logic          no_match,
  output logic          is_load,
  output logic [RW-1:0] tgt_reg,
  output logic [RW-1:0] base_reg,
  output logic [RW-1:0] ofs_reg,
  output logic [2:0]    elem_count,
  output logic [6:0]    elem_bits,
  output logic [3:0]    lane_idx,
  output logic          replicate,
  output logic [7:0]    reg_bits,
  output logic          wback,
  output logic          tag_chk,
  output logic          use_imm,
  output logic [5:0]    imm_bytes
);
  localparam logic [6:0]    FIX_NOOFS = 7'b0011010;
  localparam logic [6:0]    FIX_POST  = 7'b0011011;
  localparam logic [RW-1:0] ALL_ONES  = {RW{1'b1}};

  logic       q, l, r, s;
  logic [2:0] opc;
  logic [1:0] sz;
  logic       form_noofs, form_post, match;
  logic [1:0] scale;
  logic       bad;

  assign q   = insn[30];
  assign l   = insn[22];
  assign r   = insn[21];
  assign opc = insn[15:13];
  assign s   = insn[12];
  assign sz  = insn[11:10];

  assign tgt_reg  = insn[4:0];
  assign base_reg = insn[9:5];
  assign ofs_reg  = insn[20:16];

  assign form_noofs = !insn[31] && insn[29:23] == FIX_NOOFS && insn[20:16] == '0;
  assign form_post  = !insn[31] && insn[29:23] == FIX_POST;
  assign match      = form_noofs || form_post;

  always_comb begin
    bad       = 1'b0;
    replicate = 1'b0;
    lane_idx  = '0;
    scale     = opc[2:1];
    case (opc[2:1])
      2'b11: begin
        replicate = 1'b1;
        bad       = !l || s;
        scale     = sz;
      end
      2'b00: lane_idx = {q, s, sz};
      2'b01: begin
        bad      = sz[0];
        lane_idx = {1'b0, q, s, sz[1]};
      end
      default: begin
        bad = sz[1];
        if (!sz[0]) begin
          lane_idx = {2'b00, q, s};
        end else begin
          bad      = bad || s;
          lane_idx = {3'b000, q};
          scale    = 2'b11;
        end
      end
    endcase
  end

  assign no_match = !match;
  assign undef    = match && bad;
  assign valid    = match && !bad;
  assign is_load  = l;

  assign elem_count = {1'b0, opc[0], r} + 3'd1;
  assign elem_bits  = 7'd8 << scale;
  assign reg_bits   = 8'd64 << q;
  assign imm_bytes  = {3'b000, elem_count} << scale;

  assign wback   = form_post;
  assign tag_chk = wback || base_reg != ALL_ONES;
  assign use_imm = form_post && ofs_reg == ALL_ONES;
endmodule

// File: rtl/vls_single_decode_chk.sv
module vls_single_decode_chk (
  input logic       l_bit,
  input logic       s_bit,
  input logic       valid,
  input logic       undef,
  input logic       no_match,
  input logic       replicate,
  input logic [3:0] lane_idx,
  input logic [6:0] elem_bits,
  input logic [7:0] reg_bits,
  input logic       wback,
  input logic       tag_chk,
  input logic       use_imm,
  input logic [4:0] ofs_reg
);
  always_comb begin
    assert_one_outcome_R11: assert ($countones({valid, undef, no_match}) == 1);
    if (valid && !replicate)
      assert_lane_fits_R5: assert (((int'(lane_idx) + 1) * int'(elem_bits)) <= int'(reg_bits));
    if (valid && replicate)
      assert_rep_legal_R4: assert (l_bit && !s_bit);
    if (wback)
      assert_wback_tag_R9: assert (tag_chk && !no_match);
    if (use_imm)
      assert_imm_post_R10: assert (wback && ofs_reg == 5'd31);
  end
endmodule

bind vls_single_decode vls_single_decode_chk chk (
  .l_bit(insn[22]), .s_bit(insn[12]), .valid(valid), .undef(undef),
  .no_match(no_match), .replicate(replicate), .lane_idx(lane_idx),
  .elem_bits(elem_bits), .reg_bits(reg_bits), .wback(wback),
  .tag_chk(tag_chk), .use_imm(use_imm), .ofs_reg(ofs_reg)
);

// File: tb/vls_single_decode_test.sv
module vls_single_decode_test;
  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic [31:0] insn = '0;
  logic valid, undef, no_match, is_load, replicate, wback, tag_chk, use_imm;
  logic [4:0] tgt_reg, base_reg, ofs_reg;
  logic [2:0] elem_count;
  logic [6:0] elem_bits;
  logic [3:0] lane_idx;
  logic [7:0] reg_bits;
  logic [5:0] imm_bytes;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  vls_single_decode uut (.*);

  function automatic logic [31:0] enc(bit post, bit q, bit l, bit r, logic [4:0] rm,
                                      logic [2:0] opc, bit s, logic [1:0] sz,
                                      logic [4:0] rn, logic [4:0] rt);
    return {1'b0, q, 6'b001101, post, l, r, rm, opc, s, sz, rn, rt};
  endfunction

  typedef struct packed {
    logic [31:0] w;
    logic v, u, n, lo;
    logic [2:0] cnt;
    logic [6:0] eb;
    logic [3:0] idx;
    logic rep;
    logic [7:0] rb;
    logic wb, tg, ui;
    logic [5:0] imm;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{enc(0,1,1,0,5'd0,3'b111,0,2'b00,5'd3,5'd7),  1'b1,1'b0,1'b0,1'b1,3'd3,7'd8, 4'd0, 1'b1,8'd128,1'b0,1'b1,1'b0,6'd3},
    '{enc(1,0,1,0,5'd31,3'b111,0,2'b11,5'd31,5'd0),1'b1,1'b0,1'b0,1'b1,3'd3,7'd64,4'd0, 1'b1,8'd64, 1'b1,1'b1,1'b1,6'd24},
    '{enc(1,1,1,0,5'd5,3'b111,0,2'b01,5'd31,5'd2), 1'b1,1'b0,1'b0,1'b1,3'd3,7'd16,4'd0, 1'b1,8'd128,1'b1,1'b1,1'b0,6'd6},
    '{enc(1,1,1,0,5'd31,3'b111,0,2'b10,5'd8,5'd1), 1'b1,1'b0,1'b0,1'b1,3'd3,7'd32,4'd0, 1'b1,8'd128,1'b1,1'b1,1'b1,6'd12},
    '{enc(0,1,0,0,5'd0,3'b111,0,2'b00,5'd1,5'd1),  1'b0,1'b1,1'b0,1'b0,3'd0,7'd0, 4'd0, 1'b0,8'd0,  1'b0,1'b0,1'b0,6'd0},
    '{enc(0,1,1,0,5'd0,3'b111,1,2'b00,5'd1,5'd1),  1'b0,1'b1,1'b0,1'b0,3'd0,7'd0, 4'd0, 1'b0,8'd0,  1'b0,1'b0,1'b0,6'd0},
    '{enc(0,1,1,0,5'd0,3'b000,1,2'b10,5'd31,5'd0), 1'b1,1'b0,1'b0,1'b1,3'd1,7'd8, 4'd14,1'b0,8'd128,1'b0,1'b0,1'b0,6'd1},
    '{enc(0,0,1,1,5'd0,3'b001,0,2'b11,5'd4,5'd0),  1'b1,1'b0,1'b0,1'b1,3'd4,7'd8, 4'd3, 1'b0,8'd64, 1'b0,1'b1,1'b0,6'd4},
    '{enc(1,1,1,1,5'd31,3'b010,0,2'b10,5'd6,5'd0), 1'b1,1'b0,1'b0,1'b1,3'd2,7'd16,4'd5, 1'b0,8'd128,1'b1,1'b1,1'b1,6'd4},
    '{enc(0,0,1,0,5'd0,3'b010,0,2'b01,5'd2,5'd2),  1'b0,1'b1,1'b0,1'b0,3'd0,7'd0, 4'd0, 1'b0,8'd0,  1'b0,1'b0,1'b0,6'd0},
    '{enc(0,1,1,0,5'd0,3'b100,1,2'b00,5'd2,5'd2),  1'b1,1'b0,1'b0,1'b1,3'd1,7'd32,4'd3, 1'b0,8'd128,1'b0,1'b1,1'b0,6'd4},
    '{enc(1,1,1,1,5'd31,3'b101,0,2'b01,5'd2,5'd2), 1'b1,1'b0,1'b0,1'b1,3'd4,7'd64,4'd1, 1'b0,8'd128,1'b1,1'b1,1'b1,6'd32},
    '{enc(0,1,1,0,5'd0,3'b100,1,2'b01,5'd2,5'd2),  1'b0,1'b1,1'b0,1'b0,3'd0,7'd0, 4'd0, 1'b0,8'd0,  1'b0,1'b0,1'b0,6'd0},
    '{enc(0,1,1,0,5'd0,3'b100,0,2'b10,5'd2,5'd2),  1'b0,1'b1,1'b0,1'b0,3'd0,7'd0, 4'd0, 1'b0,8'd0,  1'b0,1'b0,1'b0,6'd0},
    '{enc(0,0,0,0,5'd0,3'b000,0,2'b00,5'd31,5'd3), 1'b1,1'b0,1'b0,1'b0,3'd1,7'd8, 4'd0, 1'b0,8'd64, 1'b0,1'b0,1'b0,6'd1},
    '{enc(0,1,1,0,5'd3,3'b111,0,2'b00,5'd1,5'd1),  1'b0,1'b0,1'b1,1'b0,3'd0,7'd0, 4'd0, 1'b0,8'd0,  1'b0,1'b0,1'b0,6'd0},
    '{enc(0,1,1,0,5'd0,3'b111,0,2'b00,5'd3,5'd7) | 32'h8000_0000,
                                                   1'b0,1'b0,1'b1,1'b0,3'd0,7'd0, 4'd0, 1'b0,8'd0,  1'b0,1'b0,1'b0,6'd0},
    '{enc(0,1,0,0,5'd0,3'b111,0,2'b00,5'd1,5'd1) ^ 32'h0400_0000,
                                                   1'b0,1'b0,1'b1,1'b0,3'd0,7'd0, 4'd0, 1'b0,8'd0,  1'b0,1'b0,1'b0,6'd0}
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    insn = w;
    @(posedge clk);
    #1ns;
  endtask

  initial begin
    #1ns;
    chk("R1", "idle word no_match", 32'(no_match), 1);
    chk("R11", "idle word valid", 32'(valid), 0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].w);
      chk("R11", "valid", 32'(valid), 32'(TBL[i].v));
      chk("R11", "undef", 32'(undef), 32'(TBL[i].u));
      chk("R1",  "no_match", 32'(no_match), 32'(TBL[i].n));
      if (TBL[i].v) begin
        chk("R12", "is_load", 32'(is_load), 32'(TBL[i].lo));
        chk("R3",  "elem_count", 32'(elem_count), 32'(TBL[i].cnt));
        chk("R8",  "elem_bits", 32'(elem_bits), 32'(TBL[i].eb));
        chk("R5",  "lane_idx", 32'(lane_idx), 32'(TBL[i].idx));
        chk("R4",  "replicate", 32'(replicate), 32'(TBL[i].rep));
        chk("R8",  "reg_bits", 32'(reg_bits), 32'(TBL[i].rb));
        chk("R9",  "wback", 32'(wback), 32'(TBL[i].wb));
        chk("R9",  "tag_chk", 32'(tag_chk), 32'(TBL[i].tg));
        chk("R10", "use_imm", 32'(use_imm), 32'(TBL[i].ui));
        chk("R10", "imm_bytes", 32'(imm_bytes), 32'(TBL[i].imm));
      end
    end

    apply(enc(1,0,1,0,5'd9,3'b111,0,2'b00,5'd17,5'd31));
    chk("R2", "tgt_reg", 32'(tgt_reg), 31);
    chk("R2", "base_reg", 32'(base_reg), 17);
    chk("R2", "ofs_reg", 32'(ofs_reg), 9);
    chk("R10", "register offset use_imm", 32'(use_imm), 0);

    apply(enc(0,1,1,0,5'd0,3'b000,0,2'b01,5'd12,5'd4));
    chk("R2", "no-offset ofs_reg", 32'(ofs_reg), 0);
    chk("R9", "no-offset wback", 32'(wback), 0);

    apply(enc(0,1,1,0,5'd0,3'b011,1,2'b10,5'd0,5'd0));
    chk("R6", "scale01 legal valid", 32'(valid), 1);
    chk("R6", "scale01 lane_idx", 32'(lane_idx), 7);
    chk("R6", "scale01 elem_bits", 32'(elem_bits), 16);
    apply(enc(0,1,1,0,5'd0,3'b011,1,2'b11,5'd0,5'd0));
    chk("R6", "scale01 size0 set undef", 32'(undef), 1);

    apply(enc(0,0,1,0,5'd0,3'b100,0,2'b01,5'd0,5'd0));
    chk("R7", "scale10 d lane_idx", 32'(lane_idx), 0);
    chk("R7", "scale10 d elem_bits", 32'(elem_bits), 64);
    apply(enc(0,0,1,0,5'd0,3'b100,1,2'b01,5'd0,5'd0));
    chk("R7", "scale10 d with S undef", 32'(undef), 1);
    apply(enc(0,0,1,0,5'd0,3'b100,0,2'b11,5'd0,5'd0));
    chk("R7", "scale10 size1 undef", 32'(undef), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule